// File: doc/BRIEF.md
# Predicated Dual-Path Output Selector

This block is the output stage of a reconfigurable processing array. It lets the array turn an if-then-else into straight-line work. Two hardwired element outputs carry the results of both arms of the conditional, and a third element computes a one-bit comparison flag. A two-bit configuration field, supplied with each instruction, sets how the final 32-bit result is picked.

There are two fixed modes and two predicated modes. A fixed mode always forwards one path. A predicated mode lets the run-time flag choose between the two paths. The candidate paths are modelled as registered element outputs with a latency set by a parameter. The flag and the configuration field are delayed by the same number of stages, so that the selection always combines values from one instruction.

Top module: `pred_out_sel`

## Requirements
- R1: While reset is high at a clock edge, every pipeline stage is cleared, so `out_valid` is 0 and `out_data` and `out_flag` are 0 until new instructions arrive.
- R2: With `sel_cfg` = 2'b00, `out_data` equals the path A value of the same instruction, whatever the flag.
- R3: With `sel_cfg` = 2'b01, `out_data` equals the path B value of the same instruction, whatever the flag.
- R4: With `sel_cfg` = 2'b10, `out_data` is path A when the flag is 1 and path B when it is 0.
- R5: With `sel_cfg` = 2'b11, `out_data` is path B when the flag is 1 and path A when it is 0.
- R6: `cmp_op` = 2'b00 sets the flag when the operands are equal, and 2'b01 sets it when they differ.
- R7: `cmp_op` = 2'b10 sets the flag when `cmp_lhs` is less than `cmp_rhs` as two's-complement numbers.
- R8: `cmp_op` = 2'b11 sets the flag when `cmp_lhs` is less than `cmp_rhs` as unsigned numbers.
- R9: Outputs appear `LAT` cycles after their inputs (default 1). The flag, the mode and both paths are aligned, so back-to-back instructions each use their own flag.
- R10: `out_valid` repeats `in_valid` delayed by `LAT` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| cand_a | input | 32 | Path A element result (one arm) |
| cand_b | input | 32 | Path B element result (other arm) |
| cmp_lhs | input | 32 | Left operand of the compare element |
| cmp_rhs | input | 32 | Right operand of the compare element |
| cmp_op | input | 2 | Compare kind: 00 eq, 01 ne, 10 signed lt, 11 unsigned lt |
| sel_cfg | input | 2 | Output mode: 00 A, 01 B, 10 flag?A:B, 11 flag?B:A |
| out_valid | output | 1 | Aligned instruction valid |
| out_data | output | 32 | Selected result |
| out_flag | output | 1 | Aligned compare flag |

## Verification
Two things happen in the same cycle. A new instruction's comparison is evaluated at the input, while the previous instruction's delayed flag steers the output multiplexer. The bench drives predicated instructions back to back with flags that alternate and with operands that sit on the signed and unsigned boundaries. A queue-based reference model then judges each output against the instruction that entered `LAT` cycles earlier. A flag that leaks between instructions, or a path that is misaligned, shows up as a mismatch on `out_data` or `out_flag`.

// File: rtl/pred_sel_pkg.sv
package pred_sel_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SEL_FIX_A  = 2'b00,
        SEL_FIX_B  = 2'b01,
        SEL_PRED_A = 2'b10,
        SEL_PRED_B = 2'b11
    } sel_mode_e;

    typedef enum logic [1:0] {
        CMP_EQ  = 2'b00,
        CMP_NE  = 2'b01,
        CMP_SLT = 2'b10,
        CMP_ULT = 2'b11
    } cmp_op_e;

    typedef struct packed {
        logic              vld;
        logic              flag;
        sel_mode_e         mode;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } stage_t;

    localparam int STAGE_W = $bits(stage_t);

endpackage

// File: rtl/pred_cmp_unit.sv
module pred_cmp_unit
    import pred_sel_pkg::*;
(
    input  cmp_op_e           op,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic              flag
);
    logic same;
    logic lt_u;
    logic lt_s;

    always_comb begin
        same = (lhs == rhs);
        lt_u = (lhs < rhs);
        // signs differ: the negative one is smaller; else unsigned order holds
        if (lhs[DATA_W-1] != rhs[DATA_W-1])
            lt_s = lhs[DATA_W-1];
        else
            lt_s = lt_u;
    end

    always_comb begin
        unique case (op)
            CMP_EQ:  flag = same;
            CMP_NE:  flag = !same;
            CMP_SLT: flag = lt_s;
            default: flag = lt_u;
        endcase
    end

    always_comb begin
        if (op == CMP_NE && lhs == rhs)
            p_ne_equal_r6: assert (!flag);
    end
endmodule

// File: rtl/pred_align_pipe.sv
module pred_align_pipe #(
    parameter int W   = 8,
    parameter int LAT = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (LAT == 0) begin : g_bypass
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] stg [LAT];
            for (genvar i = 0; i < LAT; i++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst)
                        stg[i] <= '0;
                    else if (i == 0)
                        stg[i] <= d;
                    else
                        stg[i] <= stg[(i == 0) ? 0 : i-1];
                end
            end
            assign q = stg[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/pred_out_mux.sv
module pred_out_mux
    import pred_sel_pkg::*;
(
    input  sel_mode_e         mode,
    input  logic              flag,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    logic pick_b;

    // first multiplexer: source of the select; second: the data path
    always_comb begin
        unique case (mode)
            SEL_FIX_A:  pick_b = 1'b0;
            SEL_FIX_B:  pick_b = 1'b1;
            SEL_PRED_A: pick_b = !flag;
            default:    pick_b = flag;
        endcase
        y = pick_b ? b : a;
    end
endmodule

// File: rtl/pred_out_sel.sv
module pred_out_sel
    import pred_sel_pkg::*;
#(
    parameter int LAT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] cand_a,
    input  logic [DATA_W-1:0] cand_b,
    input  logic [DATA_W-1:0] cmp_lhs,
    input  logic [DATA_W-1:0] cmp_rhs,
    input  logic [1:0]        cmp_op,
    input  logic [1:0]        sel_cfg,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_flag
);
    logic   new_flag;
    stage_t ins;
    stage_t aln;
    logic [STAGE_W-1:0] aln_raw;

    pred_cmp_unit u_cmp (
        .op   (cmp_op_e'(cmp_op)),
        .lhs  (cmp_lhs),
        .rhs  (cmp_rhs),
        .flag (new_flag)
    );

    always_comb begin
        ins.vld  = in_valid;
        ins.flag = new_flag;
        ins.mode = sel_mode_e'(sel_cfg);
        ins.a    = cand_a;
        ins.b    = cand_b;
    end

    pred_align_pipe #(.W(STAGE_W), .LAT(LAT)) u_pipe (
        .clk (clk),
        .rst (rst),
        .d   (ins),
        .q   (aln_raw)
    );

    assign aln = stage_t'(aln_raw);

    pred_out_mux u_mux (
        .mode (aln.mode),
        .flag (aln.flag),
        .a    (aln.a),
        .b    (aln.b),
        .y    (out_data)
    );

    assign out_valid = aln.vld;
    assign out_flag  = aln.flag;

    p_fix_a_r2: assert property (@(posedge clk) disable iff (rst)
        (aln.mode == SEL_FIX_A) |-> (out_data == aln.a));
    p_fix_b_r3: assert property (@(posedge clk) disable iff (rst)
        (aln.mode == SEL_FIX_B) |-> (out_data == aln.b));
    p_pred_true_r4: assert property (@(posedge clk) disable iff (rst)
        (aln.mode == SEL_PRED_A && aln.flag) |-> (out_data == aln.a));
    p_pred_false_r5: assert property (@(posedge clk) disable iff (rst)
        (aln.mode == SEL_PRED_B && !aln.flag) |-> (out_data == aln.a));

    generate
        if (LAT > 0) begin : g_reg_checks
            p_reset_clear_r1: assert property (@(posedge clk)
                $past(rst) |-> (!out_valid && out_data == '0 && !out_flag));
        end
        if (LAT == 1) begin : g_lat1_checks
            p_valid_delay_r10: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> (out_valid == $past(in_valid)));
            p_ult_align_r8: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(cmp_op) == 2'b11)
                    |-> (out_flag == $past(cmp_lhs < cmp_rhs)));
        end
    endgenerate
endmodule

// File: tb/pred_out_sel_bench.sv
module pred_out_sel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 1;
    localparam int NCYC = 600;

    typedef struct {
        logic        vld;
        logic        flag;
        logic [1:0]  mode;
        logic [1:0]  op;
        logic [31:0] data;
    } exp_t;

    logic        clk = 0;
    logic        rst = 1;
    logic        in_valid = 0;
    logic [31:0] cand_a = 0, cand_b = 0, cmp_lhs = 0, cmp_rhs = 0;
    logic [1:0]  cmp_op = 0, sel_cfg = 0;
    logic        out_valid, out_flag;
    logic [31:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pred_out_sel #(.LAT(LAT)) u_pred_out_sel (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .cand_a(cand_a), .cand_b(cand_b),
        .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs),
        .cmp_op(cmp_op), .sel_cfg(sel_cfg),
        .out_valid(out_valid), .out_data(out_data), .out_flag(out_flag)
    );

    function automatic logic ref_flag(logic [1:0] op, logic [31:0] l, logic [31:0] r);
        case (op)
            2'b00: return l == r;
            2'b01: return l != r;
            2'b10: return $signed(l) < $signed(r);
            default: return l < r;
        endcase
    endfunction

    function automatic logic [31:0] pick(logic [31:0] v);
        case (v % 7)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            5: return 32'h0000_0005;
            default: return $urandom;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic string op_req(logic [1:0] op);
        case (op)
            2'b00, 2'b01: return "R6 eq/ne flag";
            2'b10: return "R7 signed lt flag";
            default: return "R8 unsigned lt flag";
        endcase
    endfunction

    function automatic string mode_req(logic [1:0] m);
        case (m)
            2'b00: return "R2 fixed A";
            2'b01: return "R3 fixed B";
            2'b10: return "R4 pred true->A";
            default: return "R5 pred true->B";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: nothing has been clocked since reset
        check("R1 reset valid", {31'b0, out_valid}, 32'd0);
        check("R1 reset data", out_data, 32'd0);
        check("R1 reset flag", {31'b0, out_flag}, 32'd0);
        for (int i = 0; i < NCYC; i++) begin
            exp_t e;
            if (i < 32) begin
                // directed: back-to-back, flags alternate (R9)
                in_valid = 1;
                sel_cfg  = 2'(i % 4);
                cmp_op   = 2'((i / 4) % 4);
                cand_a   = 32'hA000_0000 + 32'(i);
                cand_b   = 32'hB000_0000 + 32'(i);
                cmp_lhs  = (i % 2 == 0) ? 32'h8000_0000 : 32'h0000_0007;
                cmp_rhs  = (i % 2 == 0) ? 32'h0000_0001 : 32'h0000_0007;
            end else begin
                in_valid = ($urandom % 4) != 0;
                sel_cfg  = 2'($urandom);
                cmp_op   = 2'($urandom);
                cand_a   = $urandom;
                cand_b   = $urandom;
                cmp_lhs  = pick($urandom);
                cmp_rhs  = pick($urandom);
            end
            e.vld  = in_valid;
            e.op   = cmp_op;
            e.mode = sel_cfg;
            e.flag = ref_flag(cmp_op, cmp_lhs, cmp_rhs);
            case (sel_cfg)
                2'b00: e.data = cand_a;
                2'b01: e.data = cand_b;
                2'b10: e.data = e.flag ? cand_a : cand_b;
                default: e.data = e.flag ? cand_b : cand_a;
            endcase
            q.push_back(e);
            #1;
            if (q.size() > LAT) begin
                exp_t x;
                x = q.pop_front();
                check("R10 valid delay", {31'b0, out_valid}, {31'b0, x.vld});
                check({op_req(x.op), " R9"}, {31'b0, out_flag}, {31'b0, x.flag});
                if (x.vld)
                    check({mode_req(x.mode), " R9"}, out_data, x.data);
            end
            @(negedge clk);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule